// File: doc/BRIEF.md
# Infrared Remote Carrier Output Controller

This block drives the output pin of an infrared remote transmitter from a free-running carrier that arrives from elsewhere in the chip. Software configures it through a small write-only register port. It works in one of two modes. In the software-timed mode, a gate bit passes the carrier straight to the pin. This path has no synchronisation, so the first and last carrier pulses of a burst may be cut short. In the hardware-timed mode, the block divides the carrier to get a reference period. For each transmitted bit it then opens the gate for a programmed number of reference periods (the mark) and closes it for a programmed number (the space).

In hardware mode, the gate opens and closes only on carrier rising edges, so every pulse on the pin is complete. Mark and space counts are double-buffered. Software loads the values for the next bit while the current bit is being sent. A sticky interrupt flag, raised at a programmed point inside each bit, tells software when to do this. A second output pin carries the on/off envelope of the transmission, so an external modulator or a logic analyser can follow the data.

Top module: `ir_carrier_ctrl`

## Requirements
- R1: After synchronous reset, `carrier_pin`, `envelope_pin` and `irq` are 0.
- R2: Register map (write-only, `wr_addr`): 0 = control, 1 = mark count, 2 = space count, 3 = interrupt point, 4 = interrupt clear. Control bits are: [0] carrier enable, [1] hardware mode, [2] software gate, [3] envelope enable, [5:4] divide select. In software mode, with carrier enable and gate both 1, `carrier_pin` equals `carrier_in` combinationally, with no alignment to carrier edges.
- R3: In software mode, `carrier_pin` is 0 whenever either the gate bit or the carrier enable bit is 0.
- R4: `envelope_pin` is 0 while envelope enable is 0. Otherwise it shows the active gate: in software mode, carrier enable AND the gate bit; in hardware mode, the hardware gate. The hardware gate is 1 during mark and 0 during space.
- R5: In hardware mode, the reference period is 8 << divide-select carrier periods, giving ratios of 8, 16, 32 or 64.
- R6: In hardware mode, each bit emits exactly ratio*M complete carrier pulses, followed by a gap of exactly ratio*S blocked carrier periods. M and S are the 8-bit mark and space counts, and a count of 0 acts as 1. The first bit starts on the first carrier rising edge after hardware mode is entered with carrier enable set.
- R7: Mark and space counts written during a bit take effect from the start of the next bit's mark. The bit in progress is not changed.
- R8: The interrupt flag sets on the reference-period tick at which the number of elapsed periods in the current bit equals the interrupt point. An interrupt point of 0 never fires. The flag stays set until bit 0 is written as 1 at address 4; writing 0 there does not clear it.
- R9: Clearing carrier enable, or changing the mode, resets the divider and the counters and drives both pins low. A control write that changes the mode bit also clears the stored gate bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_in | input | 1 | Free-running carrier, sampled by clk in hardware mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| carrier_pin | output | 1 | Gated carrier to the IR emitter |
| envelope_pin | output | 1 | Transmission envelope |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The embedded assertions check on every cycle that:
- the hardware gate changes only after a carrier rising edge;
- the interrupt rises only on a reference tick and holds until it is cleared;
- stopping the hardware mode returns the modulator to idle with the gate shut;
- a mode-changing control write clears the gate bit;
- both pins respect their enables.

Only the bench scenarios can show pulse and gap counts per bit for several divide ratios and counts, including zero. They also show the one-bit delay of the double-buffered counts, interrupt timing at and beyond the bit length, and the unsynchronised pass-through in software mode.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

    localparam int DATA_W        = 8;
    localparam int ADDR_W        = 3;
    localparam int DIVSEL_W      = 2;
    localparam int DIV_BASE_LOG2 = 3;
    localparam int DIV_CNT_W     = DIV_BASE_LOG2 + (2 ** DIVSEL_W) - 1;
    localparam int BIT_CNT_W     = DATA_W + 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_MARK   = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_SPACE  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_IRQPT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_IRQCLR = 3'd4;

    // control field layout, LSB first: car_en, hw_mode, gate, env_en, div_sel
    typedef struct packed {
        logic [DIVSEL_W-1:0] div_sel;
        logic                env_en;
        logic                gate;
        logic                hw_mode;
        logic                car_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [DATA_W-1:0] mark;
        logic [DATA_W-1:0] space;
    } timing_t;

    typedef enum logic [1:0] {
        PM_IDLE  = 2'd0,
        PM_MARK  = 2'd1,
        PM_SPACE = 2'd2
    } pm_state_t;

    // terminal value of the reference divider: (8 << sel) - 1
    function automatic logic [DIV_CNT_W-1:0] ratio_last(input logic [DIVSEL_W-1:0] sel);
        logic [DIV_CNT_W:0] full;
        full = (DIV_CNT_W+1)'(1) << (DIV_BASE_LOG2 + int'(sel));
        return DIV_CNT_W'(full - 1'b1);
    endfunction

    // a programmed count of zero behaves as one
    function automatic logic [DATA_W-1:0] eff_count(input logic [DATA_W-1:0] c);
        return (c == '0) ? DATA_W'(1) : c;
    endfunction

endpackage

// File: rtl/ir_regs.sv
module ir_regs
    import ir_carrier_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output timing_t           shadow,
    output logic [DATA_W-1:0] irq_pt,
    output logic              irq_clr
);

    ctrl_t ctrl_wr;

    always_comb begin
        ctrl_wr = ctrl_t'(wr_data[CTRL_W-1:0]);
        if (ctrl_wr.hw_mode != ctrl.hw_mode) begin
            ctrl_wr.gate = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            shadow <= '0;
            irq_pt <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL:  ctrl         <= ctrl_wr;
                ADDR_MARK:  shadow.mark  <= wr_data;
                ADDR_SPACE: shadow.space <= wr_data;
                ADDR_IRQPT: irq_pt       <= wr_data;
                default: ;
            endcase
        end
    end

    assign irq_clr = wr_en && (wr_addr == ADDR_IRQCLR) && wr_data[0];

    AST_MODE_CHANGE_GATE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_CTRL && wr_data[1] != ctrl.hw_mode) |=> !ctrl.gate); // R9

endmodule

// File: rtl/ir_refdiv.sv
module ir_refdiv
    import ir_carrier_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                started,
    input  logic                carrier_in,
    input  logic [DIVSEL_W-1:0] div_sel,
    output logic                car_q,
    output logic                rise,
    output logic                tick
);

    logic [DIV_CNT_W-1:0] div_cnt;
    logic                 at_last;

    assign rise    = carrier_in & ~car_q;
    assign at_last = (div_cnt == ratio_last(div_sel));
    assign tick    = started & rise & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= 1'b0;
        end else begin
            car_q <= carrier_in;
        end
    end

    // counts carrier rising edges inside one reference period
    always_ff @(posedge clk) begin
        if (rst || !started) begin
            div_cnt <= '0;
        end else if (rise) begin
            div_cnt <= at_last ? '0 : div_cnt + 1'b1;
        end
    end

    AST_DIV_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !started |=> (div_cnt == '0)); // R9

endmodule

// File: rtl/ir_pulse_mod.sv
module ir_pulse_mod
    import ir_carrier_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              rise,
    input  logic              tick,
    input  timing_t           shadow,
    input  logic [DATA_W-1:0] irq_pt,
    input  logic              irq_clr,
    output logic              started,
    output logic              gate,
    output logic              irq
);

    pm_state_t            state;
    timing_t              active;
    logic [DATA_W-1:0]    ph_cnt;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BIT_CNT_W-1:0] bit_next;
    logic                 mark_done;
    logic                 space_done;
    logic                 bit_end;
    logic                 irq_hit;

    assign started    = (state != PM_IDLE);
    assign mark_done  = (ph_cnt == eff_count(active.mark)  - 1'b1);
    assign space_done = (ph_cnt == eff_count(active.space) - 1'b1);
    assign bit_end    = tick && (state == PM_SPACE) && space_done;
    assign bit_next   = bit_cnt + 1'b1;
    assign irq_hit    = tick && (irq_pt != '0) && (bit_next == {1'b0, irq_pt});

    // mark/space sequencer
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state  <= PM_IDLE;
            gate   <= 1'b0;
            ph_cnt <= '0;
            active <= '0;
        end else begin
            case (state)
                PM_IDLE: begin
                    if (rise) begin
                        state  <= PM_MARK;
                        gate   <= 1'b1;
                        ph_cnt <= '0;
                        active <= shadow;
                    end
                end
                PM_MARK: begin
                    if (tick) begin
                        if (mark_done) begin
                            state  <= PM_SPACE;
                            gate   <= 1'b0;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                end
                PM_SPACE: begin
                    if (tick) begin
                        if (space_done) begin
                            state  <= PM_MARK;
                            gate   <= 1'b1;
                            ph_cnt <= '0;
                            active <= shadow;
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= PM_IDLE;
                    gate  <= 1'b0;
                end
            endcase
        end
    end

    // elapsed reference periods within the current bit
    always_ff @(posedge clk) begin
        if (rst || !run || state == PM_IDLE) begin
            bit_cnt <= '0;
        end else if (tick) begin
            bit_cnt <= bit_end ? '0 : bit_next;
        end
    end

    // sticky interrupt flag, set has priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (irq_hit) begin
            irq <= 1'b1;
        end else if (irq_clr) begin
            irq <= 1'b0;
        end
    end

    AST_GATE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(gate)) |-> $past(rise)); // R6

    AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick)); // R8

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R8

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> (state == PM_IDLE && !gate)); // R9

endmodule

// File: rtl/ir_carrier_ctrl.sv
module ir_carrier_ctrl
    import ir_carrier_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              carrier_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              carrier_pin,
    output logic              envelope_pin,
    output logic              irq
);

    ctrl_t             ctrl;
    timing_t           shadow;
    logic [DATA_W-1:0] irq_pt;
    logic              irq_clr;
    logic              run;
    logic              started;
    logic              car_q;
    logic              rise;
    logic              tick;
    logic              hw_gate;
    logic              sw_gate;

    assign run     = ctrl.car_en & ctrl.hw_mode;
    assign sw_gate = ctrl.car_en & ctrl.gate;

    ir_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .shadow  (shadow),
        .irq_pt  (irq_pt),
        .irq_clr (irq_clr)
    );

    ir_refdiv u_refdiv (
        .clk        (clk),
        .rst        (rst),
        .started    (started),
        .carrier_in (carrier_in),
        .div_sel    (ctrl.div_sel),
        .car_q      (car_q),
        .rise       (rise),
        .tick       (tick)
    );

    ir_pulse_mod u_pmod (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .rise    (rise),
        .tick    (tick),
        .shadow  (shadow),
        .irq_pt  (irq_pt),
        .irq_clr (irq_clr),
        .started (started),
        .gate    (hw_gate),
        .irq     (irq)
    );

    // software mode passes the raw carrier, hardware mode the registered one
    always_comb begin
        if (ctrl.hw_mode) begin
            carrier_pin  = run & hw_gate & car_q;
            envelope_pin = ctrl.env_en & run & hw_gate;
        end else begin
            carrier_pin  = sw_gate & carrier_in;
            envelope_pin = ctrl.env_en & sw_gate;
        end
    end

    AST_PIN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.car_en |-> !carrier_pin); // R3

    AST_ENV_MASK: assert property (@(posedge clk) disable iff (rst)
        !ctrl.env_en |-> !envelope_pin); // R4

endmodule

// File: tb/ir_carrier_ctrl_bench.sv
module ir_carrier_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CAR_HALF   = 2;
    localparam int CAR_PER    = 2 * CAR_HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       carrier_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       carrier_pin;
    logic       envelope_pin;
    logic       irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int pulses;
        int gap;
    } burst_t;

    burst_t exp_q[$];
    bit     mon_on = 1'b0;
    bit     pin_prev = 1'b0;
    int     cur_pulses = 0;
    int     last_rise = 0;
    int     compared = 0;
    int     gap_len;
    burst_t got_e;

    ir_carrier_ctrl u_ir_carrier_ctrl (
        .clk          (clk),
        .rst          (rst),
        .carrier_in   (carrier_in),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .carrier_pin  (carrier_pin),
        .envelope_pin (envelope_pin),
        .irq          (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            repeat (CAR_HALF) @(posedge clk);
            #1 carrier_in = ~carrier_in;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq();
        int n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(irq, "R8 interrupt arrives", int'(irq), 1);
    endtask

    task automatic push(input int pulses, input int gap);
        burst_t b;
        b.pulses = pulses;
        b.gap    = gap;
        exp_q.push_back(b);
    endtask

    task automatic mon_start();
        exp_q.delete();
        cur_pulses = 0;
        compared   = 0;
        mon_on     = 1'b1;
    endtask

    // monitor: reconstructs bursts from pin rising edges and scores them
    always @(negedge clk) begin
        if (mon_on && carrier_pin && !pin_prev) begin
            if (cur_pulses == 0) begin
                cur_pulses = 1;
            end else if (cyc - last_rise == CAR_PER) begin
                cur_pulses++;
            end else begin
                gap_len = (cyc - last_rise) / CAR_PER - 1;
                chk(envelope_pin, "R4 hw envelope on mark", int'(envelope_pin), 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected burst", cur_pulses, 0);
                end else begin
                    got_e = exp_q.pop_front();
                    chk(cur_pulses == got_e.pulses, "R6 mark pulse count", cur_pulses, got_e.pulses);
                    chk(gap_len == got_e.gap, "R6 space gap periods", gap_len, got_e.gap);
                    compared++;
                end
                cur_pulses = 1;
            end
            last_rise = cyc;
        end
        pin_prev = carrier_pin;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int mk[4] = '{3, 0, 1, 2};
        int sp[4] = '{2, 1, 0, 3};

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!carrier_pin, "R1 reset carrier_pin", int'(carrier_pin), 0);
        chk(!envelope_pin, "R1 reset envelope_pin", int'(envelope_pin), 0);
        chk(!irq, "R1 reset irq", int'(irq), 0);
        rst = 1'b0;

        // hardware run, ratio 8, changing counts each bit (R5 R6 R7)
        wr(3'd1, 8'd2); wr(3'd2, 8'd1); wr(3'd3, 8'd1);
        mon_start();
        push(16, 8);
        wr(3'd0, 8'h0B);
        for (int i = 0; i < 4; i++) begin
            wait_irq();
            repeat (3) @(negedge clk);
            chk(irq, "R8 irq sticky without clear", int'(irq), 1);
            wr(3'd4, 8'd0);
            chk(irq, "R8 writing 0 keeps irq", int'(irq), 1);
            wr(3'd4, 8'd1);
            chk(!irq, "R8 writing 1 clears irq", int'(irq), 0);
            wr(3'd1, 8'(mk[i])); wr(3'd2, 8'(sp[i]));
            push(8 * (mk[i] == 0 ? 1 : mk[i]), 8 * (sp[i] == 0 ? 1 : sp[i]));
        end
        wait_irq(); wr(3'd4, 8'd1);
        wait_irq(); wr(3'd4, 8'd1);
        chk(compared == 5, "R7 double-buffered bits scored", compared, 5);
        mon_on = 1'b0;

        // ratio 16 (R5)
        wr(3'd0, 8'h00); wr(3'd4, 8'd1);
        wr(3'd1, 8'd1); wr(3'd2, 8'd2);
        mon_start();
        push(16, 32); push(16, 32);
        wr(3'd0, 8'h1B);
        for (int i = 0; i < 3; i++) begin
            wait_irq(); wr(3'd4, 8'd1);
        end
        chk(compared == 2, "R5 ratio 16 bits scored", compared, 2);
        mon_on = 1'b0;

        // ratio 64 (R5)
        wr(3'd0, 8'h00); wr(3'd4, 8'd1);
        wr(3'd1, 8'd1); wr(3'd2, 8'd1);
        mon_start();
        push(64, 64); push(64, 64);
        wr(3'd0, 8'h3B);
        for (int i = 0; i < 3; i++) begin
            wait_irq(); wr(3'd4, 8'd1);
        end
        chk(compared == 2, "R5 ratio 64 bits scored", compared, 2);
        mon_on = 1'b0;

        // mode change clears gate and silences pins (R9)
        wr(3'd0, 8'h0D);
        begin
            int hits = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (carrier_pin || envelope_pin) hits++;
            end
            chk(hits == 0, "R9 mode switch pins low", hits, 0);
        end

        // software pass-through (R2) and envelope (R4)
        wr(3'd0, 8'h0D);
        begin
            int miss = 0;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                if (carrier_pin != carrier_in) miss++;
            end
            chk(miss == 0, "R2 sw pin follows carrier", miss, 0);
            chk(envelope_pin, "R4 sw envelope shows gate", int'(envelope_pin), 1);
        end
        wr(3'd0, 8'h09);
        begin
            int hits = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (carrier_pin) hits++;
            end
            chk(hits == 0, "R3 gate 0 pin low", hits, 0);
            chk(!envelope_pin, "R4 sw envelope gate 0", int'(envelope_pin), 0);
        end
        wr(3'd0, 8'h05);
        @(negedge clk);
        chk(!envelope_pin, "R4 envelope disabled", int'(envelope_pin), 0);
        wr(3'd0, 8'h04);
        begin
            int hits = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (carrier_pin) hits++;
            end
            chk(hits == 0, "R3 carrier enable 0 pin low", hits, 0);
        end

        // clearing carrier enable in hardware mode (R9)
        wr(3'd0, 8'h0B);
        repeat (40) @(negedge clk);
        wr(3'd0, 8'h0A);
        begin
            int hits = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (carrier_pin || envelope_pin) hits++;
            end
            chk(hits == 0, "R9 carrier enable cleared pins low", hits, 0);
        end

        // interrupt point 0 never fires (R8)
        wr(3'd0, 8'h00); wr(3'd4, 8'd1);
        wr(3'd3, 8'd0);
        wr(3'd0, 8'h0B);
        repeat (400) @(negedge clk);
        chk(!irq, "R8 point 0 never fires", int'(irq), 0);

        // point beyond bit length (2 periods) never fires (R8)
        wr(3'd0, 8'h00);
        wr(3'd3, 8'd5);
        wr(3'd0, 8'h0B);
        repeat (400) @(negedge clk);
        chk(!irq, "R8 point past bit end silent", int'(irq), 0);

        // point equal to bit length fires (R8)
        wr(3'd0, 8'h00);
        wr(3'd3, 8'd2);
        wr(3'd0, 8'h0B);
        repeat (400) @(negedge clk);
        chk(irq, "R8 point at bit end fires", int'(irq), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule